// File: doc/BRIEF.md
# Four-Channel Counter/Timer with Vectored Interrupts

This block holds four independent 8-bit down-counting channels behind a simple byte-wide write port. Each channel either times the system clock through its own prescaler (divide by 16 or by 256) or counts edges on its own trigger input. When a channel's count runs out it reloads its time constant, raises its zero-count output for one clock and, if enabled, posts an interrupt request.

Software programs one shared vector base. When the processor acknowledges an interrupt, the block returns a vector built from that base and the number of the highest-priority pending channel, and retires that channel's request. A channel is configured by writing a control word, optionally followed by its time constant. A software reset in the control word parks the channel until a fresh time constant arrives.

Top module: `quad_timer`

## Requirements
- R1: After reset all zero-count outputs, `int_req` and `vec_valid` are low and no channel counts until it receives a time constant.
- R2: A written byte with bit 0 clear sets the shared vector base (bits 7:3 kept); with bit 0 set it is a control word; when the control word has bit 2 set, the next byte written to that channel is its time constant regardless of its bit 0.
- R3: In timer mode (control bit 5 clear) the zero-count period is N x 16 clocks when control bit 4 is clear and N x 256 clocks when it is set, N being the time constant, counted from the clock edge that loads it.
- R4: A time constant of 0 gives N = 256.
- R5: In counter mode (control bit 5 set) one count is taken per edge of the channel's trigger input; control bit 3 set selects rising edges, clear selects falling edges, and the other edge has no effect.
- R6: On running out the channel reloads its time constant and keeps counting; the zero-count output is high for exactly one clock per run-out.
- R7: A run-out sets the channel's pending request only if control bit 6 (interrupt enable) is set; `int_req` is high while any request is pending.
- R8: An `int_ack` clock with a request pending makes `vec_valid` high for one clock on the next cycle with `vec_out` = {base[7:3], channel[1:0], 0}; channel 0 wins over 1, 1 over 2, 2 over 3; the winner's request is cleared.
- R9: An `int_ack` with nothing pending leaves `vec_valid` low.
- R10: A control word with bit 1 set stops the channel and clears its pending request; no further zero-count pulse occurs from it until a new time constant is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Written byte |
| trg_in | input | 4 | Per-channel clock/trigger inputs |
| zc_out | output | 4 | Per-channel zero-count pulses |
| int_req | output | 1 | Any interrupt pending |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector on `vec_out` is fresh |
| vec_out | output | 8 | Acknowledge vector |

## Verification
The bound checker watches every cycle that zero-count pulses never last two clocks, that an acknowledge yields a valid vector exactly when a request was pending, that the arbiter grants at most one channel, and that each vector carries the base held at the acknowledge edge with bit 0 clear. Period lengths, the divide selection, the 256-count meaning of zero, edge polarity in counter mode, priority order between channels and the silence after a software reset only show up in the bench's timed scenarios, which measure pulse spacing and compare returned vectors with values it computes.

// File: rtl/quad_timer_pkg.sv
package quad_timer_pkg;
  // Control word bit positions
  localparam int CB_RESET = 1;
  localparam int CB_TCF   = 2;
  localparam int CB_RISE  = 3;
  localparam int CB_DIV   = 4;
  localparam int CB_CNT   = 5;
  localparam int CB_IE    = 6;

  // Prescale terminal values
  localparam int PS_SHORT = 16;
  localparam int PS_LONG  = 256;

  typedef struct packed {
    logic ie;
    logic cnt_mode;
    logic div_long;
    logic rise;
  } chan_cfg_t;
endpackage

// File: rtl/qt_prescaler.sv
module qt_prescaler #(
  parameter int PSW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic div_long,
  output logic tick
);
  import quad_timer_pkg::*;
  localparam logic [PSW-1:0] LAST_SHORT = PSW'(PS_SHORT - 1);
  localparam logic [PSW-1:0] LAST_LONG  = PSW'(PS_LONG - 1);

  logic [PSW-1:0] ps_q, ps_n;

  always_comb begin
    tick = en && (ps_q == (div_long ? LAST_LONG : LAST_SHORT));
    ps_n = ps_q;
    if (clr)       ps_n = '0;
    else if (tick) ps_n = '0;
    else if (en)   ps_n = ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_n;
  end
endmodule

// File: rtl/qt_edge_sync.sv
module qt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise,
  output logic evt
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb evt = rise ? (s2_q & ~s3_q) : (~s2_q & s3_q);
endmodule

// File: rtl/qt_channel.sv
module qt_channel #(
  parameter int DW  = 8,
  parameter int PSW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          tc_we,
  input  logic [DW-1:0] wdata,
  input  logic          trg,
  output logic          await_tc,
  output logic          sw_rst,
  output logic          zc,
  output logic          irq_set
);
  import quad_timer_pkg::*;

  chan_cfg_t     cfg_q, cfg_n;
  logic [DW-1:0] tc_q, tc_n;
  logic [DW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;
  logic          tcf_q, tcf_n;
  logic          zc_q, zc_n;
  logic          ps_tick, edge_evt, tick;

  qt_prescaler #(.PSW(PSW)) u_ps (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tc_we | ~run_q),
    .en       (run_q & ~cfg_q.cnt_mode),
    .div_long (cfg_q.div_long),
    .tick     (ps_tick)
  );

  qt_edge_sync u_es (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (trg),
    .rise  (cfg_q.rise),
    .evt   (edge_evt)
  );

  always_comb tick = cfg_q.cnt_mode ? edge_evt : ps_tick;

  always_comb begin
    cfg_n = cfg_q;
    tc_n  = tc_q;
    cnt_n = cnt_q;
    run_n = run_q;
    tcf_n = tcf_q;
    zc_n  = 1'b0;
    if (ctl_we) begin
      cfg_n.ie       = wdata[CB_IE];
      cfg_n.cnt_mode = wdata[CB_CNT];
      cfg_n.div_long = wdata[CB_DIV];
      cfg_n.rise     = wdata[CB_RISE];
      tcf_n          = wdata[CB_TCF];
      if (wdata[CB_RESET]) run_n = 1'b0;
    end else if (tc_we) begin
      tc_n  = wdata;
      cnt_n = wdata;
      run_n = 1'b1;
      tcf_n = 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q == DW'(1)) begin
        cnt_n = tc_q;
        zc_n  = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tc_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      tcf_q <= 1'b0;
      zc_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      tc_q  <= tc_n;
      cnt_q <= cnt_n;
      run_q <= run_n;
      tcf_q <= tcf_n;
      zc_q  <= zc_n;
    end
  end

  always_comb begin
    await_tc = tcf_q;
    sw_rst   = ctl_we & wdata[CB_RESET];
    zc       = zc_q;
    irq_set  = zc_n & cfg_q.ie;
  end
endmodule

// File: rtl/qt_irq.sv
module qt_irq #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int VB_W = DW - 1 - CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  set,
  input  logic [NCH-1:0]  clr_sw,
  input  logic            ack,
  input  logic [VB_W-1:0] base,
  output logic            req,
  output logic [NCH-1:0]  grant,
  output logic            vec_valid,
  output logic [DW-1:0]   vec
);
  logic [NCH-1:0]  pend_q, pend_n;
  logic            vv_q, vv_n;
  logic [DW-1:0]   vec_q, vec_n;
  logic [CH_W-1:0] idx;
  logic            found;

  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && pend_q[i]) begin
        found    = 1'b1;
        idx      = CH_W'(i);
        grant[i] = ack;
      end
    end
  end

  always_comb begin
    pend_n = ((pend_q & ~grant) | set) & ~clr_sw;
    vv_n   = ack & found;
    vec_n  = vv_n ? {base, idx, 1'b0} : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_n;
      vv_q   <= vv_n;
      vec_q  <= vec_n;
    end
  end

  always_comb begin
    req       = |pend_q;
    vec_valid = vv_q;
    vec       = vec_q;
  end
endmodule

// File: rtl/quad_timer.sv
module quad_timer #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int PSW  = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int VB_W = DW - 1 - CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCH-1:0]  trg_in,
  output logic [NCH-1:0]  zc_out,
  output logic            int_req,
  input  logic            int_ack,
  output logic            vec_valid,
  output logic [DW-1:0]   vec_out
);
  logic [NCH-1:0]  await_tc, ctl_we, tc_we, sw_rst, irq_set, grant_w;
  logic            base_we;
  logic [VB_W-1:0] vec_base_q, vec_base_n;

  always_comb begin
    ctl_we  = '0;
    tc_we   = '0;
    base_we = 1'b0;
    if (wr_en) begin
      if (await_tc[wr_sel])  tc_we[wr_sel]  = 1'b1;
      else if (wr_data[0])   ctl_we[wr_sel] = 1'b1;
      else                   base_we        = 1'b1;
    end
    vec_base_n = base_we ? wr_data[DW-1:DW-VB_W] : vec_base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_base_q <= '0;
    else        vec_base_q <= vec_base_n;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qt_channel #(.DW(DW), .PSW(PSW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we[g]),
      .tc_we    (tc_we[g]),
      .wdata    (wr_data),
      .trg      (trg_in[g]),
      .await_tc (await_tc[g]),
      .sw_rst   (sw_rst[g]),
      .zc       (zc_out[g]),
      .irq_set  (irq_set[g])
    );
  end

  qt_irq #(.NCH(NCH), .DW(DW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (irq_set),
    .clr_sw    (sw_rst),
    .ack       (int_ack),
    .base      (vec_base_q),
    .req       (int_req),
    .grant     (grant_w),
    .vec_valid (vec_valid),
    .vec       (vec_out)
  );
endmodule

// File: rtl/quad_timer_checker.sv
module quad_timer_checker #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int VB_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  zc_out,
  input logic            int_req,
  input logic            int_ack,
  input logic            vec_valid,
  input logic [DW-1:0]   vec_out,
  input logic [NCH-1:0]  grant_w,
  input logic [VB_W-1:0] vec_base_q
);
  p_zc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_out != '0) |=> ((zc_out & $past(zc_out)) == '0));

  p_ack_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req) |=> vec_valid);

  p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req) |=> !vec_valid);

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));

  p_vec_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[DW-1:DW-VB_W] == $past(vec_base_q)));

  p_vec_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !vec_out[0]);
endmodule

bind quad_timer quad_timer_checker #(.NCH(NCH), .DW(DW), .VB_W(VB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .zc_out     (zc_out),
  .int_req    (int_req),
  .int_ack    (int_ack),
  .vec_valid  (vec_valid),
  .vec_out    (vec_out),
  .grant_w    (grant_w),
  .vec_base_q (vec_base_q)
);

// File: tb/quad_timer_tb.sv
module quad_timer_tb;
  localparam int CLK_P = 10;

  logic       clk, rst_n, wr_en, int_ack, int_req, vec_valid;
  logic [1:0] wr_sel;
  logic [7:0] wr_data, vec_out;
  logic [3:0] trg_in, zc_out;

  int checks, fails, cyc, t0;
  int zc_cnt[4], zc_last[4], zc_prev[4];
  logic [3:0] zc_seen;

  quad_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trg_in(trg_in), .zc_out(zc_out), .int_req(int_req), .int_ack(int_ack),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Pulse monitor; also checks one-clock width (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) begin
        if (zc_out[i]) begin
          if (zc_seen[i]) begin
            fails++;
            $display("FAIL R6: zc_out[%0d] high two clocks act=1 exp=0", i);
          end
          zc_cnt[i]++;
          zc_prev[i] = zc_last[i];
          zc_last[i] = cyc;
        end
      end
      zc_seen = zc_out;
    end
  end

  function automatic int exp_period(input int tc, input bit dlong);
    return ((tc == 0) ? 256 : tc) * (dlong ? 256 : 16);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(ch); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_cnt(input int ch, input int target, input int limit);
    for (int k = 0; k < limit && zc_cnt[ch] < target; k++) @(negedge clk);
  endtask

  task automatic ack(output bit vv, output logic [7:0] v);
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    vv = vec_valid; v = vec_out;
  endtask

  // Timer run: first and second periods (R2, R3, R4, R6)
  task automatic run_timer(input int ch, input int tc, input bit dlong, input string req);
    int base, p, start;
    p = exp_period(tc, dlong);
    wr(ch, 8'h07 | (dlong ? 8'h10 : 8'h00));
    wr(ch, tc);
    start = t0;
    base = zc_cnt[ch];
    wait_cnt(ch, base + 1, p + 20);
    check(zc_cnt[ch] == base + 1 && zc_last[ch] - start == p, req, zc_last[ch] - start, p);
    wait_cnt(ch, base + 2, p + 20);
    check(zc_last[ch] - zc_prev[ch] == p, "R6", zc_last[ch] - zc_prev[ch], p);
  endtask

  task automatic sw_reset_quiet(input int ch);
    int c;
    wr(ch, 8'h03);
    c = zc_cnt[ch];
    repeat (600) @(negedge clk);
    check(zc_cnt[ch] == c, "R10", zc_cnt[ch], c);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit vv;
    logic [7:0] v;
    int c, seed;
    checks = 0; fails = 0; cyc = 0; t0 = 0; zc_seen = '0;
    for (int i = 0; i < 4; i++) begin zc_cnt[i] = 0; zc_last[i] = 0; zc_prev[i] = 0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; int_ack = 1'b0; trg_in = '0;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    // R1: idle after reset
    check(zc_out == 4'h0 && int_req == 1'b0 && vec_valid == 1'b0, "R1",
          {zc_out, int_req, vec_valid}, 0);
    check(zc_cnt[0] + zc_cnt[1] + zc_cnt[2] + zc_cnt[3] == 0, "R1",
          zc_cnt[0] + zc_cnt[1] + zc_cnt[2] + zc_cnt[3], 0);

    // Random timer runs, short divide (R3), then software reset (R10)
    for (int it = 0; it < 8; it++) begin
      int ch, tc;
      ch = $urandom_range(3, 0);
      tc = $urandom_range(30, 1);
      run_timer(ch, tc, 1'b0, "R3");
      sw_reset_quiet(ch);
    end
    // Long divide (R3) and zero constant (R4)
    run_timer(1, 2, 1'b1, "R3");
    sw_reset_quiet(1);
    run_timer(2, 0, 1'b0, "R4");
    sw_reset_quiet(2);

    // R7: interrupt disabled -> pulses but no request
    c = zc_cnt[3];
    wr(3, 8'h07); wr(3, 1);
    repeat (40) @(negedge clk);
    check(zc_cnt[3] > c, "R7", zc_cnt[3] - c, 2);
    check(int_req == 1'b0, "R7", int_req, 0);
    wr(3, 8'h03);

    // R8: priority and vectors; base 0xA8 -> vectors 0xAA (ch1), 0xAC (ch2)
    wr(0, 8'hA8);
    wr(1, 8'h47); wr(1, 3);
    wr(2, 8'h47); wr(2, 2);
    repeat (50) @(negedge clk);
    check(int_req == 1'b1, "R7", int_req, 1);
    ack(vv, v);
    check(vv && v == 8'hAA, "R8", v, 8'hAA);
    ack(vv, v);
    check(vv && v == 8'hAC, "R8", v, 8'hAC);
    @(negedge clk);
    check(int_req == 1'b0, "R8", int_req, 0);
    // R10: reset clears pending
    repeat (50) @(negedge clk);
    check(int_req == 1'b1, "R7", int_req, 1);
    wr(1, 8'h03); wr(2, 8'h03);
    @(negedge clk);
    check(int_req == 1'b0, "R10", int_req, 0);
    // R9: acknowledge with nothing pending
    ack(vv, v);
    check(vv == 1'b0, "R9", vv, 0);

    // R5: counter mode, rising edges, N=3
    c = zc_cnt[0];
    wr(0, 8'h2F); wr(0, 3);
    for (int e = 0; e < 3; e++) begin
      trg_in[0] = 1'b1; repeat (4) @(negedge clk);
      trg_in[0] = 1'b0; repeat (4) @(negedge clk);
      if (e == 1) check(zc_cnt[0] == c, "R5", zc_cnt[0] - c, 0);
    end
    check(zc_cnt[0] == c + 1, "R5", zc_cnt[0] - c, 1);
    // R5: falling edges, N=2; rising edges ignored
    c = zc_cnt[0];
    wr(0, 8'h27); wr(0, 2);
    trg_in[0] = 1'b1; repeat (6) @(negedge clk);
    trg_in[0] = 1'b0; repeat (6) @(negedge clk);
    trg_in[0] = 1'b1; repeat (6) @(negedge clk);
    check(zc_cnt[0] == c, "R5", zc_cnt[0] - c, 0);
    trg_in[0] = 1'b0; repeat (6) @(negedge clk);
    check(zc_cnt[0] == c + 1, "R5", zc_cnt[0] - c, 1);

    checks++; // R6 width monitor result counted once
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule